// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 32-bit memory bus that carries two 16-bit NOR flash devices side by side. Each device owns one 16-bit half of the bus word, and both see the same command byte, because every command byte is copied into all four byte lanes. A host asks for one high-level operation at a time: identify the parts, check that they are ready, erase a block, lock or unlock a block, or program a line of up to 32 words from an internal staging buffer. The sequencer then produces the command, data and status-read cycles.

During the wait phase it polls the combined status word. It treats the pair as finished only when the ready bit of both devices is set, and it gives up once a microsecond timeout runs out. Every operation that reaches the bus ends with a read-array command, so the flash goes back to plain read mode. This includes operations that abort or time out. The result comes back as a pass flag and a 32-bit status word, together with the two identification codes.

The bus side is a simple synchronous request/acknowledge port. One request is one write or one read. The clock frequency and both timeout lengths are parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `rej`, `pass` and `mem_req` are all low.
- R2: Operation codes are: 0 identify, 1 check ready, 2 erase, 3 lock, 4 unlock, 5 line write. A request accepted while idle raises `busy` on the next cycle and holds it until the one-cycle `done` pulse, during which `busy` is low. A request made while `busy` is high is ignored and issues no bus cycle.
- R3: The following requests finish with `done` and `rej` high one cycle later, with no bus cycle: operation codes 6 and 7, and a line write whose word count is 0 or above 32 or whose address has bits [1:0] non-zero.
- R4: Identify writes 0x90909090 at the base address and reads it, then writes 0x90909090 at base+4 and reads it. `vendor_id` and `device_id` are the low 16 bits of those two reads. `pass` is high only when the low byte of the vendor code is 0x89.
- R5: Check ready writes 0x50505050, then writes 0x70707070, then reads the status word. If the word ANDed with 0x00800080 equals 0x00800080, `pass`=1 and `status`=0. Otherwise `pass`=0 and `status` holds the word read.
- R6: Erase first runs the R5 sequence and stops with that status if the pair is not ready. Otherwise it writes 0x20202020 and then 0xD0D0D0D0 at the base address and polls using the long timeout.
- R7: Lock writes 0x60606060 then 0x01010101. Unlock writes 0x60606060 then 0xD0D0D0D0. Both poll using the short timeout.
- R8: Line write writes 0xE8E8E8E8 and reads the reply. It stops with that reply unless the reply equals exactly 0x00800080. Otherwise it writes the count (words−1) copied into all four bytes, then buffer word k at base+4k, then 0xD0D0D0D0, then polls.
- R9: Polling repeats a write of 0x70707070 followed by a read until both ready bits (bit 7 and bit 23) are set. `status` takes the last word read. `pass` is high only if that word equals exactly 0x00800080, so any error bit fails the operation.
- R10: If the elapsed microseconds go beyond the timeout before both devices are ready, `status` is 0xFFFFFFFF and `pass` is 0.
- R11: Every operation that is not rejected ends with a write of 0xFFFFFFFF at the base address before `done`, including aborted and timed-out operations.
- R12: `mem_req` stays high, and `mem_we`, `mem_addr` and `mem_wdata` stay stable, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Operation request strobe |
| op | input | 3 | Operation code |
| base_addr | input | ADDR_W | Block, line or device base address |
| nwords | input | $clog2(MAX_WORDS+1) | Line write word count |
| wbuf_we | input | 1 | Staging buffer write enable |
| wbuf_idx | input | $clog2(MAX_WORDS) | Staging buffer word index |
| wbuf_data | input | 32 | Staging buffer write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | Request rejected (valid with done) |
| pass | output | 1 | Operation succeeded (valid with done) |
| status | output | 32 | Raw status result |
| vendor_id | output | 16 | Vendor code from identify |
| device_id | output | 16 | Device code from identify |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | ADDR_W | Bus cycle address |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus cycle acknowledge |
| mem_rdata | input | 32 | Bus read data, valid with acknowledge |

## Verification
A wrong sequencer state appears on the bus within a few cycles. It shows up as a wrong command word, a wrong address, a missing confirm or a missing final read-array write, and a bench that logs every write cycle sees it directly. Wrong status handling only shows when `done` fires, as a wrong `pass` or `status` value. For this reason the bench sets the flash model's reply for each case: exact ready, ready with an extra bit set, only one device ready, an error bit set, and never ready. A fault in the timeout counter can only be seen on an operation that never completes, and there it shows as a missing or late all-ones result.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [2:0] OP_IDENT  = 3'd0;
  localparam logic [2:0] OP_CHECK  = 3'd1;
  localparam logic [2:0] OP_ERASE  = 3'd2;
  localparam logic [2:0] OP_LOCK   = 3'd3;
  localparam logic [2:0] OP_UNLOCK = 3'd4;
  localparam logic [2:0] OP_LINE   = 3'd5;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_CLRSTAT = 8'h50;
  localparam logic [7:0] C_BUFPGM  = 8'hE8;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_LKSETUP = 8'h60;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LKSET   = 8'h01;

  localparam logic [31:0] BOTH_READY = 32'h0080_0080;
  localparam logic [7:0]  FAMILY_VID = 8'h89;

  typedef enum logic [4:0] {
    ST_IDLE, ST_ID_W0, ST_ID_R0, ST_ID_W1, ST_ID_R1,
    ST_CLR, ST_STW, ST_STR, ST_ERA, ST_LCK, ST_CONF,
    ST_BUF_W, ST_BUF_R, ST_CNT, ST_DPRE, ST_DAT,
    ST_PW, ST_PR, ST_FF, ST_DONE
  } seq_state_e;

  function automatic logic [31:0] lanes4(input logic [7:0] b);
    return {4{b}};
  endfunction
endpackage

// File: rtl/nor_us_timer.sv
module nor_us_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int UW     = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [UW-1:0] limit_us,
  output logic          expired
);
  localparam int DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q == PW'(DIV - 1)) begin
      pre_q <= '0;
      if (us_q != '1) us_q <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign expired = (us_q > limit_us);

  assert_expired_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> (expired || !$stable(limit_us)));
endmodule

// File: rtl/nor_line_buf.sv
module nor_line_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              fin,
  output logic [DW-1:0]     rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fin       <= 1'b0;
      rdata     <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !mem_req) begin
        mem_req   <= 1'b1;
        mem_we    <= we;
        mem_addr  <= addr;
        mem_wdata <= wdata;
      end else if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        rdata   <= mem_rdata;
        fin     <= 1'b1;
      end
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);
  assert_req_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CLK_HZ       = 50_000_000,
  parameter int SHORT_TMO_US = 1000,
  parameter int ERASE_TMO_US = 2_000_000,
  parameter int MAX_WORDS    = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req,
  input  logic [2:0]                     op,
  input  logic [ADDR_W-1:0]              base_addr,
  input  logic [$clog2(MAX_WORDS+1)-1:0] nwords,
  input  logic                           wbuf_we,
  input  logic [$clog2(MAX_WORDS)-1:0]   wbuf_idx,
  input  logic [31:0]                    wbuf_data,
  output logic                           busy,
  output logic                           done,
  output logic                           rej,
  output logic                           pass,
  output logic [31:0]                    status,
  output logic [15:0]                    vendor_id,
  output logic [15:0]                    device_id,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [31:0]                    mem_wdata,
  input  logic                           mem_ack,
  input  logic [31:0]                    mem_rdata
);
  localparam int NW     = $clog2(MAX_WORDS + 1);
  localparam int BIW    = $clog2(MAX_WORDS);
  localparam int TMO_MX = (ERASE_TMO_US > SHORT_TMO_US) ? ERASE_TMO_US : SHORT_TMO_US;
  localparam int UW     = $clog2(TMO_MX + 2);

  seq_state_e        state_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] base_q;
  logic [NW-1:0]     nw_q;
  logic [BIW-1:0]    idx_q;
  logic              issued_q;

  logic              cyc_bus, cyc_we, cyc_start, cyc_fin;
  logic [ADDR_W-1:0] cyc_addr;
  logic [31:0]       cyc_wdata, cyc_rdata, buf_rdata;
  logic [7:0]        cnt8;
  logic              rdy_both, last_word, req_ok, tmr_clr, tmr_exp;
  logic [UW-1:0]     tmr_limit;

  nor_line_buf #(.DEPTH(MAX_WORDS), .DW(32)) u_buf (
    .clk(clk), .we(wbuf_we), .waddr(wbuf_idx), .wdata(wbuf_data),
    .raddr(idx_q), .rdata(buf_rdata)
  );

  nor_us_timer #(.CLK_HZ(CLK_HZ), .UW(UW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .limit_us(tmr_limit), .expired(tmr_exp)
  );

  nor_bus_cycle #(.ADDR_W(ADDR_W), .DW(32)) u_bus (
    .clk(clk), .rst(rst), .start(cyc_start), .we(cyc_we), .addr(cyc_addr),
    .wdata(cyc_wdata), .fin(cyc_fin), .rdata(cyc_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign cnt8      = 8'(nw_q) - 8'd1;
  assign rdy_both  = ((cyc_rdata & BOTH_READY) == BOTH_READY);
  assign last_word = ((NW'(idx_q) + NW'(1)) == nw_q);
  assign tmr_limit = (op_q == OP_ERASE) ? UW'(ERASE_TMO_US) : UW'(SHORT_TMO_US);
  assign tmr_clr   = (state_q == ST_CONF) && cyc_fin;
  assign cyc_start = cyc_bus && !issued_q;

  always_comb begin
    req_ok = (op <= OP_LINE);
    if (op == OP_LINE)
      req_ok = (nwords != '0) && (nwords <= NW'(MAX_WORDS)) && (base_addr[1:0] == 2'b00);
  end

  always_comb begin
    cyc_bus   = 1'b1;
    cyc_we    = 1'b1;
    cyc_addr  = base_q;
    cyc_wdata = lanes4(C_ARRAY);
    unique case (state_q)
      ST_ID_W0:          cyc_wdata = lanes4(C_IDENT);
      ST_ID_R0:          cyc_we    = 1'b0;
      ST_ID_W1: begin
        cyc_wdata = lanes4(C_IDENT);
        cyc_addr  = base_q + ADDR_W'(4);
      end
      ST_ID_R1: begin
        cyc_we   = 1'b0;
        cyc_addr = base_q + ADDR_W'(4);
      end
      ST_CLR:            cyc_wdata = lanes4(C_CLRSTAT);
      ST_STW, ST_PW:     cyc_wdata = lanes4(C_STAT);
      ST_STR, ST_PR,
      ST_BUF_R:          cyc_we    = 1'b0;
      ST_ERA:            cyc_wdata = lanes4(C_ERASE);
      ST_LCK:            cyc_wdata = lanes4(C_LKSETUP);
      ST_CONF:           cyc_wdata = (op_q == OP_LOCK) ? lanes4(C_LKSET) : lanes4(C_CONFIRM);
      ST_BUF_W:          cyc_wdata = lanes4(C_BUFPGM);
      ST_CNT:            cyc_wdata = lanes4(cnt8);
      ST_DAT: begin
        cyc_wdata = buf_rdata;
        cyc_addr  = base_q + (ADDR_W'(idx_q) << 2);
      end
      ST_FF:             cyc_wdata = lanes4(C_ARRAY);
      default:           cyc_bus   = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      base_q    <= '0;
      nw_q      <= '0;
      idx_q     <= '0;
      issued_q  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rej       <= 1'b0;
      pass      <= 1'b0;
      status    <= '0;
      vendor_id <= '0;
      device_id <= '0;
    end else begin
      done <= 1'b0;
      if (cyc_start) issued_q <= 1'b1;
      if (cyc_fin)   issued_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          pass <= 1'b0;
          if (!req_ok) begin
            done <= 1'b1;
            rej  <= 1'b1;
          end else begin
            busy   <= 1'b1;
            rej    <= 1'b0;
            status <= '0;
            op_q   <= op;
            base_q <= base_addr;
            nw_q   <= nwords;
            idx_q  <= '0;
            unique case (op)
              OP_IDENT:            state_q <= ST_ID_W0;
              OP_CHECK, OP_ERASE:  state_q <= ST_CLR;
              OP_LOCK, OP_UNLOCK:  state_q <= ST_LCK;
              default:             state_q <= ST_BUF_W;
            endcase
          end
        end
        ST_DPRE: state_q <= ST_DAT;
        ST_DONE: begin
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: if (cyc_fin) begin
          unique case (state_q)
            ST_ID_W0: state_q <= ST_ID_R0;
            ST_ID_R0: begin
              vendor_id <= cyc_rdata[15:0];
              state_q   <= ST_ID_W1;
            end
            ST_ID_W1: state_q <= ST_ID_R1;
            ST_ID_R1: begin
              device_id <= cyc_rdata[15:0];
              pass      <= (vendor_id[7:0] == FAMILY_VID);
              state_q   <= ST_FF;
            end
            ST_CLR:   state_q <= ST_STW;
            ST_STW:   state_q <= ST_STR;
            ST_STR: begin
              if (!rdy_both) begin
                status  <= cyc_rdata;
                state_q <= ST_FF;
              end else if (op_q == OP_CHECK) begin
                pass    <= 1'b1;
                state_q <= ST_FF;
              end else begin
                state_q <= ST_ERA;
              end
            end
            ST_ERA, ST_LCK: state_q <= ST_CONF;
            ST_CONF:  state_q <= ST_PW;
            ST_BUF_W: state_q <= ST_BUF_R;
            ST_BUF_R: begin
              if (cyc_rdata != BOTH_READY) begin
                status  <= cyc_rdata;
                state_q <= ST_FF;
              end else begin
                state_q <= ST_CNT;
              end
            end
            ST_CNT:   state_q <= ST_DPRE;
            ST_DAT: begin
              if (last_word) begin
                state_q <= ST_CONF;
              end else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_DPRE;
              end
            end
            ST_PW:    state_q <= ST_PR;
            ST_PR: begin
              if (rdy_both) begin
                status  <= cyc_rdata;
                pass    <= (cyc_rdata == BOTH_READY);
                state_q <= ST_FF;
              end else if (tmr_exp) begin
                status  <= 32'hFFFF_FFFF;
                state_q <= ST_FF;
              end else begin
                state_q <= ST_PW;
              end
            end
            default:  state_q <= ST_DONE;
          endcase
        end
      endcase
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> (busy || done));
  assert_reject_nobus_R3: assert property (@(posedge clk) disable iff (rst)
    (done && rej) |-> !mem_req);
  assert_pass_exact_R9: assert property (@(posedge clk) disable iff (rst)
    (done && pass && (op_q >= OP_ERASE) && (op_q <= OP_LINE)) |-> (status == BOTH_READY));
  assert_timeout_fail_R10: assert property (@(posedge clk) disable iff (rst)
    (done && status == 32'hFFFF_FFFF) |-> !pass);
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] base_addr = '0;
  logic [5:0]  nwords = '0;
  logic        wbuf_we = 1'b0;
  logic [4:0]  wbuf_idx = '0;
  logic [31:0] wbuf_data = '0;
  logic        busy, done, rej, pass;
  logic [31:0] status;
  logic [15:0] vendor_id, device_id;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  nor_cmd_seq #(.CLK_HZ(4_000_000), .SHORT_TMO_US(20), .ERASE_TMO_US(60)) u_dut (
    .clk(clk), .rst(rst), .req(req), .op(op), .base_addr(base_addr), .nwords(nwords),
    .wbuf_we(wbuf_we), .wbuf_idx(wbuf_idx), .wbuf_data(wbuf_data),
    .busy(busy), .done(done), .rej(rej), .pass(pass), .status(status),
    .vendor_id(vendor_id), .device_id(device_id),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // flash pair model
  logic [31:0] pre_word = 32'h0080_0080;
  logic [31:0] done_word = 32'h0080_0080;
  int busy_cfg = 0;
  int busy_left = 0;
  bit id_mode = 0;
  bit armed = 0;
  logic [31:0] log_a [256];
  logic [31:0] log_d [256];
  int n_wr = 0, n_rd = 0, n_cyc = 0, viol = 0;
  logic [31:0] prev_addr = '0;
  bit prev_pend = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      prev_pend = 0;
    end else begin
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol++;
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        n_cyc++;
        if (mem_we) begin
          log_a[n_wr % 256] = mem_addr;
          log_d[n_wr % 256] = mem_wdata;
          n_wr++;
          id_mode = (mem_wdata == 32'h9090_9090);
          if (mem_wdata == 32'hD0D0_D0D0 || mem_wdata == 32'h0101_0101) begin
            busy_left = busy_cfg;
            armed = 1;
          end
          if (mem_wdata == 32'hFFFF_FFFF) armed = 0;
        end else begin
          n_rd++;
          if (id_mode) mem_rdata <= mem_addr[2] ? 32'h8801_8801 : 32'h0089_0089;
          else if (armed && busy_left > 0) begin
            busy_left--;
            mem_rdata <= 32'h0000_0000;
          end else mem_rdata <= armed ? done_word : pre_word;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  int n_checks = 0, n_err = 0;
  int wr0 = 0, rd0 = 0, cyc0 = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int k);
    return log_d[(wr0 + k) % 256];
  endfunction
  function automatic logic [31:0] wa(input int k);
    return log_a[(wr0 + k) % 256];
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [5:0] n);
    int cnt;
    wr0 = n_wr; rd0 = n_rd; cyc0 = n_cyc;
    @(negedge clk);
    req = 1'b1; op = o; base_addr = a; nwords = n;
    @(negedge clk);
    req = 1'b0;
    cnt = 0;
    while (!done && cnt < 4000) begin
      @(negedge clk);
      cnt++;
    end
    if (!done) chk("R2 watchdog done", 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 pass/rej", {30'd0, pass, rej}, 32'd0);
  endtask

  task automatic t_ident;
    run_op(3'd0, 32'h40, 6'd0);
    chk("R4 vendor", {16'd0, vendor_id}, 32'h0089);
    chk("R4 device", {16'd0, device_id}, 32'h8801);
    chk("R4 pass", {31'd0, pass}, 32'd1);
    chk("R4 w0", wd(0), 32'h9090_9090);
    chk("R4 a1", wa(1), 32'h44);
    chk("R11 ident final", wd(2), 32'hFFFF_FFFF);
    chk("R4 writes", n_wr - wr0, 32'd3);
  endtask

  task automatic t_check_ok;
    pre_word = 32'h0080_0080;
    run_op(3'd1, 32'h0, 6'd0);
    chk("R5 pass", {31'd0, pass}, 32'd1);
    chk("R5 status", status, 32'd0);
    chk("R5 clr", wd(0), 32'h5050_5050);
    chk("R5 rdsta", wd(1), 32'h7070_7070);
    chk("R11 check final", wd(2), 32'hFFFF_FFFF);
  endtask

  task automatic t_check_busy;
    pre_word = 32'h0080_0000;
    run_op(3'd1, 32'h0, 6'd0);
    chk("R5 one-ready pass", {31'd0, pass}, 32'd0);
    chk("R5 one-ready status", status, 32'h0080_0000);
    pre_word = 32'h0080_0080;
  endtask

  task automatic t_erase_ok;
    busy_cfg = 2;
    run_op(3'd2, 32'h0002_0000, 6'd0);
    chk("R6 erase cmd", wd(2), 32'h2020_2020);
    chk("R6 confirm", wd(3), 32'hD0D0_D0D0);
    chk("R9 erase polls", n_wr - wr0, 32'd8);
    chk("R6 pass", {31'd0, pass}, 32'd1);
    chk("R11 erase final", wd(7), 32'hFFFF_FFFF);
    chk("R11 final addr", wa(7), 32'h0002_0000);
    busy_cfg = 0;
  endtask

  task automatic t_erase_abort;
    pre_word = 32'h0000_0080;
    run_op(3'd2, 32'h0004_0000, 6'd0);
    chk("R6 abort status", status, 32'h0000_0080);
    chk("R6 abort pass", {31'd0, pass}, 32'd0);
    chk("R6 abort writes", n_wr - wr0, 32'd3);
    chk("R11 abort final", wd(2), 32'hFFFF_FFFF);
    pre_word = 32'h0080_0080;
  endtask

  task automatic t_lock_unlock;
    run_op(3'd3, 32'h100, 6'd0);
    chk("R7 lock setup", wd(0), 32'h6060_6060);
    chk("R7 lock set", wd(1), 32'h0101_0101);
    chk("R7 lock writes", n_wr - wr0, 32'd4);
    chk("R7 lock pass", {31'd0, pass}, 32'd1);
    run_op(3'd4, 32'h100, 6'd0);
    chk("R7 unlock setup", wd(0), 32'h6060_6060);
    chk("R7 unlock confirm", wd(1), 32'hD0D0_D0D0);
    chk("R11 unlock final", wd(3), 32'hFFFF_FFFF);
  endtask

  task automatic load_buf(input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    wbuf_we = 1'b1; wbuf_idx = i; wbuf_data = d;
    @(negedge clk);
    wbuf_we = 1'b0;
  endtask

  task automatic t_line;
    load_buf(5'd0, 32'hA5A5_0001);
    load_buf(5'd1, 32'h5A5A_0002);
    load_buf(5'd2, 32'h1234_5678);
    run_op(3'd5, 32'h200, 6'd3);
    chk("R8 bufcmd", wd(0), 32'hE8E8_E8E8);
    chk("R8 count", wd(1), 32'h0202_0202);
    chk("R8 data0", wd(2), 32'hA5A5_0001);
    chk("R8 data2", wd(4), 32'h1234_5678);
    chk("R8 addr2", wa(4), 32'h208);
    chk("R8 confirm", wd(5), 32'hD0D0_D0D0);
    chk("R8 writes", n_wr - wr0, 32'd8);
    chk("R8 pass", {31'd0, pass}, 32'd1);
  endtask

  task automatic t_line_abort;
    pre_word = 32'h0080_0081;
    run_op(3'd5, 32'h300, 6'd1);
    chk("R8 inexact abort status", status, 32'h0080_0081);
    chk("R8 abort writes", n_wr - wr0, 32'd2);
    chk("R11 line abort final", wd(1), 32'hFFFF_FFFF);
    pre_word = 32'h0080_0080;
  endtask

  task automatic t_line_err;
    busy_cfg = 1;
    done_word = 32'h0080_0090;
    run_op(3'd5, 32'h400, 6'd1);
    chk("R9 error status", status, 32'h0080_0090);
    chk("R9 error pass", {31'd0, pass}, 32'd0);
    chk("R9 poll reads", n_rd - rd0, 32'd3);
    busy_cfg = 0;
    done_word = 32'h0080_0080;
  endtask

  task automatic t_timeout;
    busy_cfg = 100000;
    run_op(3'd4, 32'h500, 6'd0);
    chk("R10 status", status, 32'hFFFF_FFFF);
    chk("R10 pass", {31'd0, pass}, 32'd0);
    chk("R11 timeout final", log_d[(n_wr - 1) % 256], 32'hFFFF_FFFF);
    busy_cfg = 0;
  endtask

  task automatic t_reject;
    run_op(3'd5, 32'h600, 6'd0);
    chk("R3 zero count rej", {31'd0, rej}, 32'd1);
    run_op(3'd5, 32'h600, 6'd33);
    chk("R3 over count rej", {31'd0, rej}, 32'd1);
    run_op(3'd5, 32'h602, 6'd4);
    chk("R3 misaligned rej", {31'd0, rej}, 32'd1);
    chk("R3 misaligned no bus", n_cyc - cyc0, 32'd0);
    run_op(3'd7, 32'h0, 6'd0);
    chk("R3 bad op rej", {31'd0, rej}, 32'd1);
    chk("R3 bad op no bus", n_cyc - cyc0, 32'd0);
  endtask

  task automatic t_ignore;
    int cnt;
    busy_cfg = 3;
    wr0 = n_wr;
    @(negedge clk);
    req = 1'b1; op = 3'd3; base_addr = 32'h700; nwords = 6'd0;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 busy high", {31'd0, busy}, 32'd1);
    req = 1'b1; op = 3'd0;
    @(negedge clk);
    req = 1'b0;
    cnt = 0;
    while (!done && cnt < 4000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R2 done low busy", {31'd0, busy}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R2 ignored req writes", n_wr - wr0, 32'd7);
    chk("R2 no ident cmd", wd(6), 32'hFFFF_FFFF);
    busy_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ident();
    t_check_ok();
    t_check_busy();
    t_erase_ok();
    t_erase_abort();
    t_lock_unlock();
    t_line();
    t_line_abort();
    t_line_err();
    t_timeout();
    t_reject();
    t_ignore();
    chk("R12 handshake stable", viol, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL R2 global watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule